// File: doc/BRIEF.md
# Sticky Receiver Error Status Register

This block gathers error and status conditions from a digital audio receiver and its clock-recovery loop into one 8-bit read-only status word. Each condition is sampled only on the framing boundary that belongs to it: per sub-frame, per channel-status block or per Q-subcode block. Once captured, the bit stays set until the host reads the word. A per-bit enable mask selects which conditions may appear at all. An interrupt output is raised while any bit is set.

A read does not clear a bit whose source condition is still active at the moment of the read. A persistent fault, such as a loop that stays out of lock, therefore remains visible. An error that coincides with a read is never lost. The decoder, the CRC checkers and the loop itself sit outside this block and feed it level signals and boundary strobes.

Top module: `rx_err_status_reg`

## Requirements
- R1: Bit 7 of `status_q` always reads 0. Bits 6 down to 0 are, in order: Q-subcode CRC error, channel-status CRC error, loop unlocked, validity flag, confidence error, bi-phase error and parity error. `mask_en` bits 6..0 enable the same positions.
- R2: An enabled bit sets at a clock edge where its source level is 1 and its boundary strobe is 1. The bit is visible in `status_q` after that edge.
- R3: The Q-subcode CRC bit samples only on `qblock_stb`. The channel-status CRC and unlocked bits sample only on `cblock_stb`. The validity, confidence, bi-phase and parity bits sample only on `frame_stb`. A source at 1 without its own strobe sets nothing.
- R4: A set bit stays set in later cycles, whatever its source does, until a read or a mask clear.
- R5: A cycle with `rd_stb` = 1 clears every set bit whose source level is 0 in that cycle. A set bit whose source is still 1 stays 1.
- R6: If a bit's set event and `rd_stb` fall in the same cycle, the bit is 1 after that edge.
- R7: A bit with its `mask_en` bit at 0 reads 0 after the next edge, whatever its source does. Clearing the enable discards the stored bit, and enabling it again does not restore it.
- R8: The channel-status CRC bit sets only while `pro_mode` = 1.
- R9: Synchronous reset `rst` = 1 drives `status_q` to 8'h00 and `irq` to 0.
- R10: `irq` is 1 exactly when some bit of `status_q` is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qsub_crc_err | input | 1 | Q-subcode CRC error level |
| cstat_crc_err | input | 1 | Channel-status CRC error level |
| pll_unlocked | input | 1 | Clock-recovery loop out of lock |
| validity_flag | input | 1 | Received validity flag (1 = invalid) |
| confidence_err | input | 1 | Eye-opening confidence error level |
| biphase_err | input | 1 | Bi-phase coding error level |
| parity_err | input | 1 | Sub-frame parity error level |
| frame_stb | input | 1 | Sub-frame boundary strobe |
| cblock_stb | input | 1 | Channel-status block boundary strobe |
| qblock_stb | input | 1 | Q-subcode block boundary strobe |
| pro_mode | input | 1 | 1 = professional channel-status format |
| mask_en | input | 7 | Per-bit enable, positions as in R1 |
| rd_stb | input | 1 | Register read strobe |
| status_q | output | 8 | Status word |
| irq | output | 1 | Any status bit set |

## Verification
The hardest case to reach is a read that lands while some latched bits have a source that has gone away and others have a source that is still asserted. Only the first group may clear in that case. The stimulus table builds this state on purpose: it first sets the bits with mixed strobes. Then it issues reads while one source is held high and the others are low, and also a read in the same cycle as a fresh sub-frame event. Mask drops on latched bits, followed by re-enabling, confirm that nothing stale comes back.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int NUM_SRC = 7;
  localparam int REG_W   = NUM_SRC + 1;

  localparam int BIT_PAR  = 0;
  localparam int BIT_BIP  = 1;
  localparam int BIT_CONF = 2;
  localparam int BIT_VAL  = 3;
  localparam int BIT_UNLK = 4;
  localparam int BIT_CCRC = 5;
  localparam int BIT_QCRC = 6;

  typedef enum logic [1:0] {BND_FRAME, BND_CBLOCK, BND_QBLOCK} bnd_e;

  function automatic bnd_e bnd_of(input int idx);
    if (idx == BIT_QCRC) return BND_QBLOCK;
    if (idx == BIT_CCRC || idx == BIT_UNLK) return BND_CBLOCK;
    return BND_FRAME;
  endfunction
endpackage

// File: rtl/rxerr_boundary_map.sv
module rxerr_boundary_map
  import rxerr_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] src_raw,
  input  logic         frame_stb,
  input  logic         cblock_stb,
  input  logic         qblock_stb,
  input  logic         pro_mode,
  output logic [N-1:0] src_lvl,
  output logic [N-1:0] src_evt
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic stb;
    if (i == BIT_CCRC) begin : g_pro
      assign src_lvl[i] = src_raw[i] & pro_mode;
    end else begin : g_any
      assign src_lvl[i] = src_raw[i];
    end
    if (bnd_of(i) == BND_QBLOCK) begin : g_q
      assign stb = qblock_stb;
    end else if (bnd_of(i) == BND_CBLOCK) begin : g_c
      assign stb = cblock_stb;
    end else begin : g_f
      assign stb = frame_stb;
    end
    assign src_evt[i] = src_lvl[i] & stb;
  end
endmodule

// File: rtl/rxerr_latch_cell.sv
module rxerr_latch_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic evt,
  input  logic lvl,
  input  logic rd,
  output logic q,
  output logic q_next
);
  always_comb begin
    if (!en)      q_next = 1'b0;
    else if (evt) q_next = 1'b1;
    else if (rd)  q_next = q & lvl;
    else          q_next = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end
endmodule

// File: rtl/rx_err_status_reg.sv
module rx_err_status_reg
  import rxerr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               qsub_crc_err,
  input  logic               cstat_crc_err,
  input  logic               pll_unlocked,
  input  logic               validity_flag,
  input  logic               confidence_err,
  input  logic               biphase_err,
  input  logic               parity_err,
  input  logic               frame_stb,
  input  logic               cblock_stb,
  input  logic               qblock_stb,
  input  logic               pro_mode,
  input  logic [NUM_SRC-1:0] mask_en,
  input  logic               rd_stb,
  output logic [REG_W-1:0]   status_q,
  output logic               irq
);
  logic [NUM_SRC-1:0] src_raw, src_lvl, src_evt, bits_q, bits_nxt;

  always_comb begin
    src_raw           = '0;
    src_raw[BIT_QCRC] = qsub_crc_err;
    src_raw[BIT_CCRC] = cstat_crc_err;
    src_raw[BIT_UNLK] = pll_unlocked;
    src_raw[BIT_VAL]  = validity_flag;
    src_raw[BIT_CONF] = confidence_err;
    src_raw[BIT_BIP]  = biphase_err;
    src_raw[BIT_PAR]  = parity_err;
  end

  rxerr_boundary_map #(.N(NUM_SRC)) u_map (
    .src_raw(src_raw), .frame_stb(frame_stb), .cblock_stb(cblock_stb),
    .qblock_stb(qblock_stb), .pro_mode(pro_mode),
    .src_lvl(src_lvl), .src_evt(src_evt)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    rxerr_latch_cell u_cell (
      .clk(clk), .rst(rst), .en(mask_en[i]), .evt(src_evt[i]),
      .lvl(src_lvl[i]), .rd(rd_stb), .q(bits_q[i]), .q_next(bits_nxt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |bits_nxt;
  end

  assign status_q = {1'b0, bits_q};
endmodule

// File: rtl/rxerr_status_chk.sv
module rxerr_status_chk
  import rxerr_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               qsub_crc_err,
  input logic               cstat_crc_err,
  input logic               pll_unlocked,
  input logic               validity_flag,
  input logic               confidence_err,
  input logic               biphase_err,
  input logic               parity_err,
  input logic               frame_stb,
  input logic               cblock_stb,
  input logic               qblock_stb,
  input logic               pro_mode,
  input logic [NUM_SRC-1:0] mask_en,
  input logic               rd_stb,
  input logic [REG_W-1:0]   status_q,
  input logic               irq
);
  logic [NUM_SRC-1:0] src, stb;
  assign src = {qsub_crc_err, cstat_crc_err & pro_mode, pll_unlocked, validity_flag,
                confidence_err, biphase_err, parity_err};
  assign stb = {qblock_stb, cblock_stb, cblock_stb, frame_stb, frame_stb, frame_stb, frame_stb};

  assert_top_zero_R1: assert property (@(posedge clk) disable iff (rst) status_q[REG_W-1] == 1'b0);
  assert_irq_any_R10: assert property (@(posedge clk) disable iff (rst) irq == (|status_q));
  assert_reset_clear_R9: assert property (@(posedge clk) rst |=> (status_q == '0 && !irq));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_a
    assert_set_event_R2: assert property (@(posedge clk) disable iff (rst)
      (mask_en[i] && src[i] && stb[i]) |=> status_q[i]);
    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      (status_q[i] && mask_en[i] && !rd_stb) |=> status_q[i]);
    assert_read_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && !src[i]) |=> !status_q[i]);
    assert_mask_off_R7: assert property (@(posedge clk) disable iff (rst)
      !mask_en[i] |=> !status_q[i]);
    assert_no_stray_R3: assert property (@(posedge clk) disable iff (rst)
      (!status_q[i] && !(src[i] && stb[i])) |=> !status_q[i]);
  end
endmodule

bind rx_err_status_reg rxerr_status_chk u_chk (.*);

// File: tb/rx_err_status_reg_bench.sv
`timescale 1ns/1ps
module rx_err_status_reg_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic qsub_crc_err, cstat_crc_err, pll_unlocked, validity_flag;
  logic confidence_err, biphase_err, parity_err;
  logic frame_stb, cblock_stb, qblock_stb, pro_mode, rd_stb;
  logic [6:0] mask_en;
  logic [7:0] status_q;
  logic irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rx_err_status_reg u_rx_err_status_reg (.*);

  // row: {mask[6:0], pro, src[6:0] (Q,C,U,V,CF,B,P), stb {q,c,f}, rd, expected status}
  localparam int NV = 16;
  localparam logic [26:0] VEC [NV] = '{
    {7'h7F,1'b1,7'b0000001,3'b001,1'b0,8'h01}, // R2 parity sets on frame
    {7'h7F,1'b1,7'b0000000,3'b000,1'b0,8'h01}, // R4 sticky
    {7'h7F,1'b1,7'b1000000,3'b001,1'b0,8'h01}, // R3 Q without qblock
    {7'h7F,1'b1,7'b1000000,3'b100,1'b0,8'h41}, // R2 Q on qblock
    {7'h7F,1'b0,7'b0100000,3'b010,1'b0,8'h41}, // R8 consumer mode
    {7'h7F,1'b1,7'b0100000,3'b010,1'b0,8'h61}, // R8 professional mode
    {7'h7F,1'b1,7'b0010000,3'b001,1'b0,8'h61}, // R3 unlock on frame only
    {7'h7F,1'b1,7'b0010000,3'b010,1'b0,8'h71}, // R2 unlock on cblock
    {7'h7F,1'b1,7'b0010000,3'b000,1'b1,8'h10}, // R5 read keeps live unlock
    {7'h7F,1'b1,7'b0000000,3'b000,1'b1,8'h00}, // R5 read clears
    {7'h7F,1'b1,7'b0001111,3'b001,1'b0,8'h0F}, // R2 four frame bits
    {7'h7F,1'b1,7'b0000100,3'b001,1'b1,8'h04}, // R6 event with read
    {7'h7E,1'b1,7'b0000001,3'b001,1'b0,8'h04}, // R7 masked parity
    {7'h7B,1'b1,7'b0000000,3'b000,1'b0,8'h00}, // R7 mask drop clears
    {7'h7F,1'b1,7'b0000000,3'b000,1'b0,8'h00}, // R7 re-enable no restore
    {7'h7F,1'b1,7'b0001000,3'b110,1'b0,8'h00}  // R3 V without frame
  };

  task automatic drive(input logic [6:0] m, input logic p, input logic [6:0] s,
                       input logic [2:0] b, input logic r);
    mask_en = m; pro_mode = p;
    {qsub_crc_err, cstat_crc_err, pll_unlocked, validity_flag,
     confidence_err, biphase_err, parity_err} = s;
    {qblock_stb, cblock_stb, frame_stb} = b;
    rd_stb = r;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    drive(7'h7F, 1'b1, 7'h00, 3'b000, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    check("R9 reset status", status_q, 8'h00);
    check("R9 reset irq", {7'h0, irq}, 8'h00);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][26:20], VEC[i][19], VEC[i][18:12], VEC[i][11:9], VEC[i][8]);
      @(posedge clk);
      #1;
      check($sformatf("R1/R2-R8 row %0d status", i), status_q, VEC[i][7:0]);
      check($sformatf("R10 row %0d irq", i), {7'h0, irq}, {7'h0, |VEC[i][7:0]});
    end
    // directed: all bits at once, bit 7 stays 0
    @(negedge clk) drive(7'h7F, 1'b1, 7'h7F, 3'b111, 1'b0);
    @(posedge clk); #1;
    check("R1 all set", status_q, 8'h7F);
    @(negedge clk) drive(7'h7F, 1'b1, 7'h00, 3'b000, 1'b0);
    @(posedge clk); #1;
    check("R10 irq held", {7'h0, irq}, 8'h01);
    // directed: reset clears latched bits
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R9 mid reset status", status_q, 8'h00);
    check("R9 mid reset irq", {7'h0, irq}, 8'h00);
    @(negedge clk) rst = 1'b0;
    // directed: read while source live but not yet latched sets nothing
    drive(7'h7F, 1'b1, 7'b0000010, 3'b000, 1'b1);
    @(posedge clk); #1;
    check("R3 live source read", status_q, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule